// File: doc/BRIEF.md
# Fixed-Window I/O Target for a Multiplexed 32-bit Parallel Bus

This block lets a simple peripheral answer single-word I/O reads and writes on a 32-bit parallel bus that carries address and data on the same AD lines. It has no configuration space. It claims an access when the address falls in a 4-byte window, and a static 16-bit base input, set like a switch, places that window.

A claimed write stores the low 16 bits of the data phase in an output register. A claimed read returns a 16-bit input port on AD, with the upper half zero. The block drives DEVSEL#, TRDY# and AD through separate value and enable outputs. The chip's pad logic combines them into tri-state lines. It generates no parity and checks none. After a transfer completes, it drives DEVSEL# and TRDY# high for one clock and then releases them. With no wait states, a write takes 3 clocks and a read takes 4.

Top module: `pci_io_target`

## Requirements
- R1: While reset is held, and on the first clock after it, every output enable (DEVSEL#, TRDY#, AD) is low and the output port reads zero.
- R2: The block claims an access when the address bits 15..2 on AD equal bits 15..2 of the base input. AD bits 31..16 and base bits 1..0 have no effect, so base F300h covers F300h through F303h.
- R3: During the address phase, only the command codes 0010 (I/O read) and 0011 (I/O write) on C/BE# are claimed. Any other code, or an address outside the window, leaves DEVSEL# released and the output port unchanged.
- R4: On a claimed write, DEVSEL# and TRDY# are driven low one clock after the address phase. The low 16 bits of AD are latched into the output port on the first clock edge where IRDY# is low. Until then the port holds its value.
- R5: On a claimed read, the clock after the address phase drives DEVSEL# low and TRDY# high, with AD not driven. On the next clock, AD is driven with {16'h0, input port} and TRDY# is driven low.
- R6: A read holds its data phase, with AD and TRDY# still driven, until an edge where IRDY# is low.
- R7: After the final data phase completes, DEVSEL# and TRDY# are driven high for exactly one clock. On the following clock both enables are low.
- R8: The AD enable is high only during the read data phase. It is never high in the address phase or in the turnaround clock that follows it.
- R9: An address phase is recognised only on an edge where FRAME# is low after having been high on the previous edge. A FRAME# held low does not trigger a second decode.
- R10: The output port changes only on a completed write data phase. Reads and ignored cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_addr | input | 16 | Static window base; bits 1..0 ignored |
| frame_n | input | 1 | FRAME# sampled from the bus |
| irdy_n | input | 1 | IRDY# sampled from the bus |
| cbe_n | input | 4 | C/BE# sampled from the bus |
| ad_in | input | 32 | AD sampled from the bus |
| ad_out | output | 32 | Read data to drive on AD |
| ad_oe | output | 1 | AD drive enable |
| devsel_n | output | 1 | DEVSEL# value |
| devsel_oe | output | 1 | DEVSEL# drive enable |
| trdy_n | output | 1 | TRDY# value |
| trdy_oe | output | 1 | TRDY# drive enable |
| port_in | input | 16 | Input port returned on reads |
| port_out | output | 16 | Latched output port written by I/O writes |

## Verification
Every sequencer state maps to a distinct combination of the three enables and the two strobe values. A wrong state therefore shows up at the ports on the very clock it is entered. Examples are a missed claim, TRDY# asserted in the turnaround clock, or a stuck drive-high clock. A wrong data capture shows on port_out, or on ad_out in the read data phase, one edge after the data phase. The directed cases sample each of those clocks, with and without wait states, at window edges, just outside the window, with foreign commands and with a held FRAME#.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WDATA,
        ST_RTURN,
        ST_RDATA,
        ST_DONE
    } tgt_state_e;

    localparam logic [3:0] CMD_IO_READ  = 4'b0010;
    localparam logic [3:0] CMD_IO_WRITE = 4'b0011;
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [3:0]        cmd_n,
    output logic              hit_rd,
    output logic              hit_wr
);
    localparam int TOP = ADDR_W - 1;

    logic in_window;

    always_comb begin
        in_window = (addr[TOP:WIN_BITS] == base[TOP:WIN_BITS]);
        hit_rd    = in_window && (cmd_n == CMD_IO_READ);
        hit_wr    = in_window && (cmd_n == CMD_IO_WRITE);
    end
endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
    import pci_tgt_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              hit_rd,
    input  logic              hit_wr,
    input  logic [PORT_W-1:0] wr_bus,
    input  logic [PORT_W-1:0] port_in,
    output logic [PORT_W-1:0] port_out,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    output logic              devsel_n,
    output logic              devsel_oe,
    output logic              trdy_n,
    output logic              trdy_oe
);
    localparam int PAD_W = BUS_W - PORT_W;

    typedef struct packed {
        tgt_state_e        state;
        logic              frame_prev;
        logic [PORT_W-1:0] wr_data;
        logic [PORT_W-1:0] rd_data;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        state:      ST_IDLE,
        frame_prev: 1'b1,
        wr_data:    '0,
        rd_data:    '0
    };

    regs_t r_q, r_d;
    logic  addr_start;

    always_comb begin
        r_d            = r_q;
        r_d.frame_prev = frame_n;
        addr_start     = r_q.frame_prev && !frame_n;
        unique case (r_q.state)
            ST_IDLE: begin
                if (addr_start && hit_wr)      r_d.state = ST_WDATA;
                else if (addr_start && hit_rd) r_d.state = ST_RTURN;
            end
            ST_WDATA: begin
                if (!irdy_n) begin
                    r_d.wr_data = wr_bus;
                    r_d.state   = ST_DONE;
                end
            end
            ST_RTURN: begin
                r_d.rd_data = port_in;
                r_d.state   = ST_RDATA;
            end
            ST_RDATA: begin
                if (!irdy_n) r_d.state = ST_DONE;
            end
            ST_DONE:  r_d.state = ST_IDLE;
            default:  r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    always_comb begin
        devsel_oe = (r_q.state != ST_IDLE);
        trdy_oe   = devsel_oe;
        devsel_n  = (r_q.state == ST_DONE);
        trdy_n    = !((r_q.state == ST_WDATA) || (r_q.state == ST_RDATA));
        ad_oe     = (r_q.state == ST_RDATA);
        ad_out    = {{PAD_W{1'b0}}, r_q.rd_data};
        port_out  = r_q.wr_data;
    end
endmodule

// File: rtl/pci_io_target.sv
module pci_io_target #(
    parameter int BUS_W    = 32,
    parameter int ADDR_W   = 16,
    parameter int PORT_W   = 16,
    parameter int WIN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [3:0]        cbe_n,
    input  logic [BUS_W-1:0]  ad_in,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    output logic              devsel_n,
    output logic              devsel_oe,
    output logic              trdy_n,
    output logic              trdy_oe,
    input  logic [PORT_W-1:0] port_in,
    output logic [PORT_W-1:0] port_out
);
    logic hit_rd, hit_wr;

    pci_tgt_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BITS(WIN_BITS)
    ) u_decode (
        .addr  (ad_in[ADDR_W-1:0]),
        .base  (base_addr),
        .cmd_n (cbe_n),
        .hit_rd(hit_rd),
        .hit_wr(hit_wr)
    );

    pci_tgt_ctrl #(
        .BUS_W (BUS_W),
        .PORT_W(PORT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .hit_rd   (hit_rd),
        .hit_wr   (hit_wr),
        .wr_bus   (ad_in[PORT_W-1:0]),
        .port_in  (port_in),
        .port_out (port_out),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .devsel_n (devsel_n),
        .devsel_oe(devsel_oe),
        .trdy_n   (trdy_n),
        .trdy_oe  (trdy_oe)
    );
endmodule

// File: rtl/pci_tgt_checker.sv
module pci_tgt_checker #(
    parameter int BUS_W  = 32,
    parameter int PORT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irdy_n,
    input logic [BUS_W-1:0]  ad_in,
    input logic              ad_oe,
    input logic              devsel_n,
    input logic              devsel_oe,
    input logic              trdy_n,
    input logic              trdy_oe,
    input logic [PORT_W-1:0] port_out
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!devsel_oe && !trdy_oe && !ad_oe && port_out == '0));

    assert_strobes_paired_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trdy_oe == devsel_oe);

    assert_write_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_oe && !devsel_n && !trdy_n && !ad_oe && !irdy_n)
        |=> port_out == $past(ad_in[PORT_W-1:0]));

    assert_read_after_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> $past(devsel_oe && !devsel_n && trdy_n));

    assert_release_after_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_oe && devsel_n) |=> (!devsel_oe && !trdy_oe));

    assert_ad_only_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (devsel_oe && !devsel_n && trdy_oe && !trdy_n));

    assert_port_only_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_out) |-> $past(devsel_oe && !devsel_n && !trdy_n && !ad_oe && !irdy_n));
endmodule

bind pci_io_target pci_tgt_checker #(
    .BUS_W (BUS_W),
    .PORT_W(PORT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irdy_n   (irdy_n),
    .ad_in    (ad_in),
    .ad_oe    (ad_oe),
    .devsel_n (devsel_n),
    .devsel_oe(devsel_oe),
    .trdy_n   (trdy_n),
    .trdy_oe  (trdy_oe),
    .port_out (port_out)
);

// File: tb/sim_pci_io_target.sv
module sim_pci_io_target;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] base_addr = 16'hF300;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, devsel_oe, trdy_n, trdy_oe;
    logic [15:0] port_in = '0;
    logic [15:0] port_out;

    int compared = 0;
    int mismatched = 0;
    logic [15:0] exp_port = '0;

    always #10 clk = ~clk;

    pci_io_target u0 (
        .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .frame_n(frame_n),
        .irdy_n(irdy_n), .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .devsel_n(devsel_n), .devsel_oe(devsel_oe),
        .trdy_n(trdy_n), .trdy_oe(trdy_oe), .port_in(port_in), .port_out(port_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 enables in reset", {29'd0, devsel_oe, trdy_oe, ad_oe}, 32'd0);
        chk("R1 port in reset", {16'd0, port_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 enables after reset", {29'd0, devsel_oe, trdy_oe, ad_oe}, 32'd0);
        chk("R1 port after reset", {16'd0, port_out}, 32'd0);
    endtask

    task automatic t_write(input logic [31:0] addr, input logic [31:0] data, input int waits);
        @(negedge clk);
        frame_n = 1'b0; cbe_n = 4'b0011; ad_in = addr; irdy_n = 1'b1;
        @(negedge clk);
        chk("R4 write claim", {27'd0, devsel_oe, devsel_n, trdy_oe, trdy_n, ad_oe}, {27'd0, 5'b10100});
        frame_n = 1'b1; cbe_n = 4'h0; ad_in = data; irdy_n = (waits > 0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk("R4 port held in write wait", {16'd0, port_out}, {16'd0, exp_port});
            chk("R4 strobes held in write wait", {30'd0, devsel_n, trdy_n}, 32'd0);
        end
        irdy_n = 1'b0;
        @(negedge clk);
        exp_port = data[15:0];
        chk("R4 write latched", {16'd0, port_out}, {16'd0, exp_port});
        chk("R7 write drive high", {28'd0, devsel_oe, devsel_n, trdy_oe, trdy_n}, 32'hF);
        irdy_n = 1'b1; ad_in = '0;
        @(negedge clk);
        chk("R7 write released", {29'd0, devsel_oe, trdy_oe, ad_oe}, 32'd0);
    endtask

    task automatic t_read(input logic [31:0] addr, input logic [15:0] pin, input int waits);
        port_in = pin;
        @(negedge clk);
        frame_n = 1'b0; cbe_n = 4'b0010; ad_in = addr; irdy_n = 1'b1;
        @(negedge clk);
        chk("R5 read turnaround", {27'd0, devsel_oe, devsel_n, trdy_oe, trdy_n}, {27'd0, 4'b1011});
        chk("R8 no AD in turnaround", {31'd0, ad_oe}, 32'd0);
        frame_n = 1'b1; cbe_n = 4'h0; ad_in = '0; irdy_n = (waits > 0);
        @(negedge clk);
        chk("R5 read data driven", {31'd0, ad_oe}, 32'd1);
        chk("R5 read data value", ad_out, {16'd0, pin});
        chk("R5 read trdy low", {31'd0, trdy_n}, 32'd0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk("R6 read wait holds", {30'd0, ad_oe, trdy_n}, 32'd2);
            chk("R6 read wait data", ad_out, {16'd0, pin});
        end
        irdy_n = 1'b0;
        @(negedge clk);
        chk("R7 read drive high", {27'd0, devsel_oe, devsel_n, trdy_oe, trdy_n, ad_oe}, {27'd0, 5'b11110});
        chk("R10 port kept by read", {16'd0, port_out}, {16'd0, exp_port});
        irdy_n = 1'b1;
        @(negedge clk);
        chk("R7 read released", {29'd0, devsel_oe, trdy_oe, ad_oe}, 32'd0);
    endtask

    task automatic t_ignore(input string req, input logic [31:0] addr, input logic [3:0] cmd);
        @(negedge clk);
        frame_n = 1'b0; cbe_n = cmd; ad_in = addr; irdy_n = 1'b1;
        @(negedge clk);
        chk(req, {31'd0, devsel_oe}, 32'd0);
        frame_n = 1'b1; cbe_n = 4'h0; ad_in = 32'h0000_5A5A; irdy_n = 1'b0;
        @(negedge clk);
        chk(req, {30'd0, devsel_oe, ad_oe}, 32'd0);
        chk("R10 port kept by ignored cycle", {16'd0, port_out}, {16'd0, exp_port});
        irdy_n = 1'b1; ad_in = '0;
        @(negedge clk);
    endtask

    task automatic t_held_frame();
        @(negedge clk);
        frame_n = 1'b0; cbe_n = 4'b0011; ad_in = 32'h0000_F400;
        @(negedge clk);
        ad_in = 32'h0000_F300;
        @(negedge clk);
        chk("R9 held frame no claim", {31'd0, devsel_oe}, 32'd0);
        frame_n = 1'b1; ad_in = '0; cbe_n = 4'h0;
        @(negedge clk);
        chk("R9 held frame still idle", {30'd0, devsel_oe, trdy_oe}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_write(32'h0000_F300, 32'h0000_1234, 0);
        t_write(32'hABCD_F302, 32'hFFFF_BEEF, 2);          // R2 upper bits ignored
        t_read(32'h0000_F301, 16'hC0DE, 0);
        t_read(32'h1234_F303, 16'h8001, 3);                 // R2 top of window
        t_ignore("R3 just above window", 32'h0000_F304, 4'b0011);
        t_ignore("R3 just below window", 32'h0000_F2FF, 4'b0011);
        t_ignore("R3 memory write ignored", 32'h0000_F300, 4'b0111);
        t_ignore("R3 config read ignored", 32'h0000_F300, 4'b1010);
        t_held_frame();
        base_addr = 16'h0403;                                // R2 base low bits ignored
        t_write(32'h0000_0401, 32'h0000_00A5, 1);
        t_read(32'h0000_0400, 16'h7E7E, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(20 * 200000);
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule